// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single line and presents each completed byte in a data register. Software reads the data and status through a small register bus. Status holds a data-ready flag and three sticky error flags: overrun, framing and parity. A mode register enables an optional parity bit and selects odd or even parity. The bit timing comes from an external tick at sixteen times the bit rate. A falling edge on the line starts a frame. The start bit is confirmed at its midpoint, and every later bit is sampled in the middle of its bit period.

Each error type has its own rule for the data register:
- An overrun leaves the data register untouched.
- Framing and parity errors still deliver the byte.

No flag clears on a read. Software must first read the status register while the flag is set, and then write a 0 to that flag's bit.

The receive state machine has five states:
- `RX_IDLE` waits for a high-to-low edge on the line and then goes to `RX_START`.
- `RX_START` counts half a bit. If the line is still low at the midpoint it goes to `RX_DATA`; if the line is high it returns to `RX_IDLE`.
- `RX_DATA` samples eight bits, one every sixteen ticks. After the last bit it goes to `RX_PARITY` when parity is on, and to `RX_STOP` otherwise.
- `RX_PARITY` samples the parity bit and goes to `RX_STOP`.
- `RX_STOP` samples the stop bit, reports the frame and returns to `RX_IDLE`.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset the status, data and mode registers all read as 0.
- R2: A frame is 1 start bit (0), 8 data bits sent LSB first, an optional parity bit and 1 stop bit (1). With the data-ready flag clear, a completed frame loads its byte into the data register and sets the data-ready flag.
- R3: Parity is checked when mode bit 0 is 1. Mode bit 1 selects the kind: 1 means an odd count of ones over data plus parity, 0 means even. On a mismatch the parity flag is set and the byte is still loaded.
- R4: A stop bit sampled as 0 sets the framing flag, and the byte is still loaded.
- R5: A frame that completes while the data-ready flag is 1 sets the overrun flag and leaves the data register unchanged.
- R6: When one frame has several errors, every matching flag is set together.
- R7: A flag clears when software writes 0 to its bit, provided the most recent status read before that write returned the flag as 1.
- R8: Writing 0 to a flag bit that has not been read as 1 since the flag was set has no effect. Writing 1 to any flag bit has no effect.
- R9: Reading the data register does not clear the data-ready flag.
- R10: Register map, chosen by the 2-bit select:
  - Select 0 is status: bit 0 data-ready, bit 1 overrun, bit 2 framing, bit 3 parity, other bits 0.
  - Select 1 is data.
  - Select 2 is mode (bits 1:0, read/write).
- R11: A low pulse on the line that lasts less than half a bit period is rejected as a false start and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| reg_sel | input | 2 | Register select: 0 status, 1 data, 2 mode |
| reg_rd | input | 1 | Read strobe; a status read arms the flags that read as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |

## Verification
Register reads are combinational. The value is sampled during the read-strobe cycle, and the strobe arms the flags at the edge that ends that cycle. A write takes effect at the edge that ends the write-strobe cycle, so the bench reads it back one cycle after that edge or later.

The line passes through two synchronising flops. The stop bit is sampled at its midpoint. The flags and data then update two edges after that sampling tick, which is roughly half a bit time before the line frame ends. The bench therefore checks results only after a full frame plus more than a bit time of idle line, where every result is settled, and it compares against a bench model of flags, arming and data.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    localparam int FLAG_N   = 4;
    localparam int FL_READY = 0;
    localparam int FL_OVR   = 1;
    localparam int FL_FRM   = 2;
    localparam int FL_PAR   = 3;

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_DATA   = 2'd1;
    localparam logic [1:0] SEL_MODE   = 2'd2;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] byte_out,
    output logic          ferr,
    output logic          perr
);
    localparam int CW   = $clog2(OS);
    localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
    localparam int HALF = OS / 2;

    rx_state_e     state, nstate;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] shreg;
    logic          par_bit;
    logic          rx_prev;
    logic          end_bit, mid_start, last_bit;

    assign end_bit   = tick && (cnt == CW'(OS - 1));
    assign mid_start = tick && (cnt == CW'(HALF - 1));
    assign last_bit  = (bit_idx == BW'(DW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE:   if (rx_prev && !rx) nstate = RX_START;
            RX_START:  if (mid_start) nstate = rx ? RX_IDLE : RX_DATA;
            RX_DATA:   if (end_bit && last_bit) nstate = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (end_bit) nstate = RX_STOP;
            RX_STOP:   if (end_bit) nstate = RX_IDLE;
            default:   nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            rx_prev  <= 1'b1;
            done     <= 1'b0;
            byte_out <= '0;
            ferr     <= 1'b0;
            perr     <= 1'b0;
        end else begin
            rx_prev <= rx;
            done    <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                end
                RX_START: begin
                    if (tick) cnt <= mid_start ? '0 : cnt + 1'b1;
                end
                RX_DATA: begin
                    if (tick) cnt <= end_bit ? '0 : cnt + 1'b1;
                    if (end_bit) begin
                        shreg   <= {rx, shreg[DW-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) cnt <= end_bit ? '0 : cnt + 1'b1;
                    if (end_bit) par_bit <= rx;
                end
                RX_STOP: begin
                    if (tick) cnt <= end_bit ? '0 : cnt + 1'b1;
                    if (end_bit) begin
                        done     <= 1'b1;
                        byte_out <= shreg;
                        ferr     <= !rx;
                        perr     <= par_en && (par_bit != ((^shreg) ^ par_odd));
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rx_flag_regs.sv
module rx_flag_regs
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DW-1:0]     byte_in,
    input  logic              ferr,
    input  logic              perr,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [FLAG_N-1:0] wbits,
    output logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] armed,
    output logic [DW-1:0]     data_q
);
    logic [FLAG_N-1:0] set_v, clr_v;

    always_comb begin
        set_v           = '0;
        set_v[FL_READY] = done && !flags[FL_READY];
        set_v[FL_OVR]   = done &&  flags[FL_READY];
        set_v[FL_FRM]   = done && ferr;
        set_v[FL_PAR]   = done && perr;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        assign clr_v[i] = stat_wr && armed[i] && !wbits[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                armed[i] <= 1'b0;
            end else begin
                flags[i] <= set_v[i] || (flags[i] && !clr_v[i]);
                if (stat_rd)       armed[i] <= flags[i];
                else if (clr_v[i]) armed[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         data_q <= '0;
        else if (done && !flags[FL_READY]) data_q <= byte_in;
    end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic [1:0]    reg_sel,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);
    logic [1:0]        rx_sync;
    logic [1:0]        mode_q;
    logic              frame_done, frame_ferr, frame_perr;
    logic [DW-1:0]     frame_byte;
    logic [FLAG_N-1:0] flags, flag_armed;
    logic [DW-1:0]     data_q;
    logic              stat_rd, stat_wr;

    assign stat_rd = reg_rd && (reg_sel == SEL_STATUS);
    assign stat_wr = reg_wr && (reg_sel == SEL_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync <= 2'b11;
            mode_q  <= 2'b00;
        end else begin
            rx_sync <= {rx_sync[0], rxd};
            if (reg_wr && reg_sel == SEL_MODE) mode_q <= reg_wdata[1:0];
        end
    end

    rx_frame_fsm #(.OS(OS), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rx       (rx_sync[1]),
        .par_en   (mode_q[0]),
        .par_odd  (mode_q[1]),
        .done     (frame_done),
        .byte_out (frame_byte),
        .ferr     (frame_ferr),
        .perr     (frame_perr)
    );

    rx_flag_regs #(.DW(DW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frame_done),
        .byte_in (frame_byte),
        .ferr    (frame_ferr),
        .perr    (frame_perr),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wbits   (reg_wdata[FLAG_N-1:0]),
        .flags   (flags),
        .armed   (flag_armed),
        .data_q  (data_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_STATUS: reg_rdata[FLAG_N-1:0] = flags;
            SEL_DATA:   reg_rdata = data_q;
            SEL_MODE:   reg_rdata[1:0] = mode_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_done,
    input logic [DW-1:0] frame_byte,
    input logic          frame_ferr,
    input logic          frame_perr,
    input logic [3:0]    flags,
    input logic [3:0]    flag_armed,
    input logic [DW-1:0] data_q,
    input logic          stat_wr
);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !flags[0] |=> flags[0] && data_q == $past(frame_byte));

    assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && frame_perr |=> flags[3]);

    assert_framing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && frame_ferr |=> flags[2]);

    assert_overrun_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && flags[0] |=> flags[1] && $stable(data_q));

    assert_unarmed_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && flags[0] && !flag_armed[0] |=> flags[0]);

    assert_unarmed_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && flags[1] && !flag_armed[1] |=> flags[1]);

    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(stat_wr));
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .frame_ferr (frame_ferr),
    .frame_perr (frame_perr),
    .flags      (flags),
    .flag_armed (flag_armed),
    .data_q     (data_q),
    .stat_wr    (stat_wr)
);

// File: tb/uart_rx_flags_test.sv
`timescale 1ns/1ps
module uart_rx_flags_test;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] tdiv = 2'd0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [3:0] m_flags = 4'h0;
    logic [3:0] m_armed = 4'h0;
    logic [7:0] m_data  = 8'h00;
    logic [1:0] m_mode  = 2'b00;

    always #5 clk = ~clk;

    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    uart_rx_flags uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_after(input logic [3:0] f, input logic bad_stop,
                                               input logic bad_par);
        logic [3:0] r = f;
        if (f[0]) r[1] = 1'b1;
        else      r[0] = 1'b1;
        if (bad_stop) r[2] = 1'b1;
        if (bad_par)  r[3] = 1'b1;
        return r;
    endfunction

    task automatic bus_read(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel;
        reg_rd  = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (sel == 2'd0) m_armed = m_flags;
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel == 2'd2) m_mode = val[1:0];
        if (sel == 2'd0) begin
            for (int i = 0; i < 4; i++) begin
                if (m_armed[i] && !val[i]) begin
                    m_flags[i] = 1'b0;
                    m_armed[i] = 1'b0;
                end
            end
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        rxd = b;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        logic pbit;
        pbit = (^b) ^ m_mode[1] ^ bad_par;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        if (m_mode[0]) drive_bit(pbit);
        drive_bit(!bad_stop);
        @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK + 32) @(negedge clk);
        if (!m_flags[0]) m_data = b;
        m_flags = flags_after(m_flags, bad_stop, m_mode[0] && bad_par);
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        bus_read(2'd0, v);
        chk(req, v, {4'h0, m_flags});
        bus_read(2'd1, v);
        chk(req, v, m_data);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R10: reset values
        bus_read(2'd0, v); chk("R1 status", v, 8'h00);
        bus_read(2'd1, v); chk("R1 data", v, 8'h00);
        bus_read(2'd2, v); chk("R1 mode", v, 8'h00);

        // R10: mode read back
        bus_write(2'd2, 8'h03);
        bus_read(2'd2, v); chk("R10 mode", v, 8'h03);
        bus_write(2'd2, 8'h00);

        // R2: plain frame, no parity, no reads in between (arming stays clear)
        send_frame(8'hA5, 1'b0, 1'b0);
        // R8: write 0 and write 1 without a prior read of the flag
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'hFF);
        check_regs("R2 R8 ready kept");
        // R9: data read keeps ready flag
        bus_read(2'd1, v); chk("R9 data", v, 8'hA5);
        bus_read(2'd0, v); chk("R9 ready", v, 8'h01);
        // R7: read then write 0 clears
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, v); chk("R7 clear", v, 8'h00);

        // R5: overrun keeps data
        send_frame(8'h3C, 1'b0, 1'b0);
        send_frame(8'hC3, 1'b0, 1'b0);
        check_regs("R5 overrun");

        // R6: parity + framing + overrun on one frame
        bus_write(2'd2, 8'h01);
        send_frame(8'h81, 1'b1, 1'b1);
        check_regs("R6 multi");
        bus_write(2'd0, 8'h00);
        check_regs("R7 clear all");

        // R3: odd parity good then bad; R4 framing alone
        bus_write(2'd2, 8'h03);
        send_frame(8'h17, 1'b0, 1'b0);
        check_regs("R3 odd good");
        bus_write(2'd0, 8'h00);
        send_frame(8'h6E, 1'b1, 1'b0);
        check_regs("R3 odd bad");
        bus_write(2'd0, 8'h00);
        send_frame(8'h55, 1'b0, 1'b1);
        check_regs("R4 framing");
        bus_write(2'd0, 8'h00);

        // R11: short low pulse rejected
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        check_regs("R11 glitch");
        send_frame(8'h96, 1'b0, 1'b0);
        check_regs("R11 after glitch R2");

        // random mix
        for (int n = 0; n < 25; n++) begin
            logic [7:0] b;
            logic bp, bs;
            b  = 8'($urandom);
            bp = ($urandom % 5) == 0;
            bs = ($urandom % 5) == 0;
            bus_write(2'd2, {6'h0, 2'($urandom)});
            send_frame(b, bp, bs);
            check_regs("R2 R3 R4 R5 R6 random");
            if ($urandom % 2) begin
                bus_read(2'd0, v);
                chk("R7 random read", v, {4'h0, m_flags});
            end
            bus_write(2'd0, {4'h0, 4'($urandom)});
            check_regs("R7 R8 random clear");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule